// File: doc/BRIEF.md
# ULPI link-side bus controller

This block is the link end of an 8-bit ULPI bus. It runs on the 60 MHz clock that the PHY supplies. The PHY decides who owns the shared data bus through its direction line, and the controller follows it. It never drives the bus while the PHY owns it. It keeps one turnaround cycle on every change of ownership, in which it neither drives nor samples. Received bytes are passed upward, each with a flag that marks a status byte.

On the transmit side, the block takes a byte stream through a valid/ready port with a last marker. It puts each byte on the bus and holds it until the PHY's accept line confirms it. It closes the stream with a single-cycle stop pulse after the final byte. A separate request input makes the block issue a register write that sets the transceiver-reset bit in the PHY. When both are waiting, the write goes before any packet.

If the PHY takes the bus in the middle of a stream, the transmit is cut short. The block reports an abort pulse and sends no stop. It then quietly consumes the rest of that packet from upstream. An interrupted register write is kept pending and sent again once the bus is free.

Top module: `ulpi_link_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `bus_dout_en`, `link_stop`, `rx_valid`, `tx_abort` and `xrst_done` are all low.
- R2: `bus_dout_en` is low in every cycle that follows a sampled high on `phy_drives`.
- R3: A new transmit or register write drives the bus only after `phy_drives` has been sampled low on two consecutive rising edges, so that the turnaround cycle after the PHY releases the bus is never used.
- R4: While the link drives the bus, `bus_dout` holds its byte through every cycle in which `phy_accept` is sampled low. After an accept, the next upstream byte appears in the following cycle. Bytes reach the bus in upstream order, with none lost or repeated.
- R5: After the byte marked last is accepted, `link_stop` is high for exactly one cycle with `bus_dout` = 00h. In the cycle after that, `link_stop` and `bus_dout_en` are low.
- R6: A pulse on `xrst_req` produces a register write of three bus cycles or more: the command byte 84h (prefix bits 7:6 = 10b, address bits 5:0 = 04h), then the data byte 20h (bit 5 set), each held until accepted, then a one-cycle stop. `xrst_done` pulses for one cycle right after the stop.
- R7: When a register write request and an upstream packet both wait for the bus, the register write is sent first and the packet follows it.
- R8: If `phy_drives` is sampled high while a packet byte is on the bus, `bus_dout_en` drops and `tx_abort` pulses for one cycle, with no `link_stop` for that stream. The remaining bytes of the packet, up to its last marker, are taken from upstream with `tx_ready` high and never reach the bus.
- R9: A register write cut off by `phy_drives` also pulses `tx_abort`. It stays pending and is sent again in full once the bus is free.
- R10: A byte is captured to `rx_data` only when `phy_drives` was high on this edge and on the one before. `rx_valid` then pulses one cycle later. `rx_is_status` is 1 when `phy_accept` was low with that byte and 0 when it was high. The turnaround byte is never captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY-supplied 60 MHz clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| phy_drives | input | 1 | Bus direction from the PHY; high means the PHY owns the data bus |
| phy_accept | input | 1 | PHY throttle: accepts the link's byte, or marks a data byte when the PHY drives |
| bus_din | input | 8 | Data bus as driven by the PHY |
| bus_dout | output | 8 | Data the link puts on the bus |
| bus_dout_en | output | 1 | Output enable for the link's bus drivers |
| link_stop | output | 1 | One-cycle end-of-stream pulse to the PHY |
| tx_data | input | 8 | Upstream transmit byte |
| tx_valid | input | 1 | Upstream byte is valid |
| tx_last | input | 1 | Upstream byte is the last of its packet |
| tx_ready | output | 1 | Upstream byte is taken on this rising edge |
| xrst_req | input | 1 | Request to write the transceiver-reset bit |
| xrst_done | output | 1 | One-cycle pulse when that write has completed |
| tx_abort | output | 1 | One-cycle pulse when the PHY cut off a transmit or write |
| rx_data | output | 8 | Byte received from the PHY |
| rx_valid | output | 1 | `rx_data` holds a new byte |
| rx_is_status | output | 1 | The received byte is a status byte rather than packet data |

## Verification
The properties assume that the PHY changes `phy_drives` and `phy_accept` only in step with `clk`, and raises `phy_accept` only while the link is driving or the PHY owns the bus. They also assume that upstream keeps `tx_valid` high from the first byte of a packet through its last. The bench's PHY model sets its lines at the falling edge. It raises accept only while `bus_dout_en` is high and `link_stop` is low, or in its own receive bursts. The upstream driver presents every byte of a packet one after another without a gap. Ownership changes, including a take-over in the middle of a stream, are produced only through the direction line, so turnaround and abort arise from the same causes a real PHY would produce.

// File: rtl/ulpi_link_pkg.sv
package ulpi_link_pkg;

  // Width of the shared bus and of a register address field.
  localparam int ULPI_W     = 8;
  localparam int REG_ADDR_W = 6;

  // Upper bits of a register-write command byte.
  localparam logic [ULPI_W-REG_ADDR_W-1:0] REGW_PREFIX = 2'b10;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PKT,
    S_PKT_STOP,
    S_DRAIN,
    S_RW_CMD,
    S_RW_DATA,
    S_RW_STOP
  } link_state_e;

endpackage

// File: rtl/ulpi_own_track.sv
module ulpi_own_track (
  input  logic clk,
  input  logic rst_n,
  input  logic phy_drives,
  output logic bus_free,
  output logic phy_owned
);

  // Direction seen on the previous edge; a mismatch with the current value
  // marks a turnaround cycle. After reset, ownership is treated as unsettled.
  logic drv_q;
  logic drv_d;

  always_comb begin
    drv_d = phy_drives;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= 1'b1;
    end else begin
      drv_q <= drv_d;
    end
  end

  assign bus_free  = !phy_drives && !drv_q;
  assign phy_owned =  phy_drives &&  drv_q;

endmodule

// File: rtl/ulpi_rx_capture.sv
module ulpi_rx_capture
  import ulpi_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phy_owned,
  input  logic              phy_accept,
  input  logic [ULPI_W-1:0] bus_din,
  output logic [ULPI_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_is_status
);

  logic              cap_en;
  logic              vld_d;
  logic [ULPI_W-1:0] data_d;
  logic              stat_d;

  always_comb begin
    cap_en = phy_owned;
    vld_d  = phy_owned;
    data_d = bus_din;
    stat_d = !phy_accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data      <= '0;
      rx_is_status <= 1'b0;
    end else if (cap_en) begin
      rx_data      <= data_d;
      rx_is_status <= stat_d;
    end
  end

endmodule

// File: rtl/ulpi_tx_engine.sv
module ulpi_tx_engine
  import ulpi_link_pkg::*;
#(
  parameter logic [REG_ADDR_W-1:0] XRST_ADDR = 6'h04,
  parameter int                    XRST_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phy_drives,
  input  logic              phy_accept,
  input  logic              bus_free,
  input  logic [ULPI_W-1:0] tx_data,
  input  logic              tx_valid,
  input  logic              tx_last,
  output logic              tx_ready,
  input  logic              xrst_req,
  output logic              xrst_done,
  output logic              tx_abort,
  output logic [ULPI_W-1:0] bus_dout,
  output logic              bus_dout_en,
  output logic              link_stop
);

  localparam logic [ULPI_W-1:0] REGW_CMD = {REGW_PREFIX, XRST_ADDR};
  localparam logic [ULPI_W-1:0] REGW_VAL = {{(ULPI_W-1){1'b0}}, 1'b1} << XRST_BIT;

  link_state_e       state_q, state_d;
  logic [ULPI_W-1:0] dout_q, dout_d;
  logic              oe_q, oe_d;
  logic              stop_q, stop_d;
  logic              abort_q, abort_d;
  logic              done_q, done_d;
  logic              last_q, last_d;
  logic              pend_q, pend_d;
  logic              ready_c;

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    dout_d  = dout_q;
    oe_d    = oe_q;
    last_d  = last_q;
    pend_d  = pend_q || xrst_req;
    stop_d  = 1'b0;
    abort_d = 1'b0;
    done_d  = 1'b0;
    ready_c = 1'b0;

    unique case (state_q)
      S_IDLE: begin
        oe_d   = 1'b0;
        dout_d = '0;
        if (bus_free) begin
          if (pend_q || xrst_req) begin
            state_d = S_RW_CMD;
            dout_d  = REGW_CMD;
            oe_d    = 1'b1;
          end else begin
            ready_c = 1'b1;
            if (tx_valid) begin
              state_d = S_PKT;
              dout_d  = tx_data;
              last_d  = tx_last;
              oe_d    = 1'b1;
            end
          end
        end
      end

      S_PKT: begin
        if (phy_drives) begin
          state_d = last_q ? S_IDLE : S_DRAIN;
          oe_d    = 1'b0;
          dout_d  = '0;
          abort_d = 1'b1;
        end else if (phy_accept) begin
          if (last_q) begin
            state_d = S_PKT_STOP;
            dout_d  = '0;
            stop_d  = 1'b1;
          end else begin
            ready_c = 1'b1;
            if (tx_valid) begin
              dout_d = tx_data;
              last_d = tx_last;
            end
          end
        end
      end

      S_PKT_STOP: begin
        state_d = S_IDLE;
        oe_d    = 1'b0;
      end

      S_DRAIN: begin
        ready_c = 1'b1;
        oe_d    = 1'b0;
        if (tx_valid && tx_last) begin
          state_d = S_IDLE;
        end
      end

      S_RW_CMD: begin
        if (phy_drives) begin
          state_d = S_IDLE;
          oe_d    = 1'b0;
          dout_d  = '0;
          abort_d = 1'b1;
        end else if (phy_accept) begin
          state_d = S_RW_DATA;
          dout_d  = REGW_VAL;
        end
      end

      S_RW_DATA: begin
        if (phy_drives) begin
          state_d = S_IDLE;
          oe_d    = 1'b0;
          dout_d  = '0;
          abort_d = 1'b1;
        end else if (phy_accept) begin
          state_d = S_RW_STOP;
          dout_d  = '0;
          stop_d  = 1'b1;
        end
      end

      S_RW_STOP: begin
        state_d = S_IDLE;
        oe_d    = 1'b0;
        done_d  = 1'b1;
        pend_d  = xrst_req;
      end

      default: begin
        state_d = S_IDLE;
        oe_d    = 1'b0;
        dout_d  = '0;
      end
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dout_q  <= '0;
      oe_q    <= 1'b0;
      stop_q  <= 1'b0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
      last_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dout_q  <= dout_d;
      oe_q    <= oe_d;
      stop_q  <= stop_d;
      abort_q <= abort_d;
      done_q  <= done_d;
      last_q  <= last_d;
      pend_q  <= pend_d;
    end
  end

  assign tx_ready    = ready_c;
  assign bus_dout    = dout_q;
  assign bus_dout_en = oe_q;
  assign link_stop   = stop_q;
  assign tx_abort    = abort_q;
  assign xrst_done   = done_q;

endmodule

// File: rtl/ulpi_link_ctrl.sv
module ulpi_link_ctrl
  import ulpi_link_pkg::*;
#(
  parameter logic [REG_ADDR_W-1:0] XRST_ADDR = 6'h04,
  parameter int                    XRST_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phy_drives,
  input  logic              phy_accept,
  input  logic [ULPI_W-1:0] bus_din,
  output logic [ULPI_W-1:0] bus_dout,
  output logic              bus_dout_en,
  output logic              link_stop,
  input  logic [ULPI_W-1:0] tx_data,
  input  logic              tx_valid,
  input  logic              tx_last,
  output logic              tx_ready,
  input  logic              xrst_req,
  output logic              xrst_done,
  output logic              tx_abort,
  output logic [ULPI_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_is_status
);

  logic bus_free;
  logic phy_owned;

  ulpi_own_track own_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .phy_drives (phy_drives),
    .bus_free   (bus_free),
    .phy_owned  (phy_owned)
  );

  ulpi_rx_capture rx_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .phy_owned    (phy_owned),
    .phy_accept   (phy_accept),
    .bus_din      (bus_din),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_is_status (rx_is_status)
  );

  ulpi_tx_engine #(
    .XRST_ADDR (XRST_ADDR),
    .XRST_BIT  (XRST_BIT)
  ) tx_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .phy_drives  (phy_drives),
    .phy_accept  (phy_accept),
    .bus_free    (bus_free),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_last     (tx_last),
    .tx_ready    (tx_ready),
    .xrst_req    (xrst_req),
    .xrst_done   (xrst_done),
    .tx_abort    (tx_abort),
    .bus_dout    (bus_dout),
    .bus_dout_en (bus_dout_en),
    .link_stop   (link_stop)
  );

endmodule

// File: rtl/ulpi_link_ctrl_chk.sv
module ulpi_link_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phy_drives,
  input logic       phy_accept,
  input logic [7:0] bus_dout,
  input logic       bus_dout_en,
  input logic       link_stop,
  input logic       tx_abort,
  input logic       xrst_done,
  input logic       rx_valid,
  input logic       rx_is_status
);

  AST_NO_DRIVE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(phy_drives) |-> !bus_dout_en); // R2

  AST_START_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_dout_en) |-> !$past(phy_drives)); // R3

  AST_HOLD_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_dout_en) && bus_dout_en && !$past(phy_accept)) |-> $stable(bus_dout)); // R4

  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    link_stop |=> !link_stop); // R5

  AST_STOP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_stop) |-> ($past(phy_accept) && $past(bus_dout_en))); // R5

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    link_stop |=> !bus_dout_en); // R5

  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    xrst_done |-> $past(link_stop)); // R6

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> (!link_stop && !bus_dout_en && $past(phy_drives) && $past(bus_dout_en))); // R8

  AST_RX_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(phy_drives)); // R10

  AST_STATUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_is_status == !$past(phy_accept))); // R10

endmodule

bind ulpi_link_ctrl ulpi_link_ctrl_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .phy_drives   (phy_drives),
  .phy_accept   (phy_accept),
  .bus_dout     (bus_dout),
  .bus_dout_en  (bus_dout_en),
  .link_stop    (link_stop),
  .tx_abort     (tx_abort),
  .xrst_done    (xrst_done),
  .rx_valid     (rx_valid),
  .rx_is_status (rx_is_status)
);

// File: tb/ulpi_link_ctrl_tb_top.sv
module ulpi_link_ctrl_tb_top;

  localparam int CLK_PERIOD = 16;
  localparam int WDOG_LIMIT = 20000;
  localparam logic [8:0] END_MARK = 9'h100;

  logic       clk;
  logic       rst_n;
  logic       phy_drives;
  logic       phy_accept;
  logic [7:0] bus_din;
  logic [7:0] bus_dout;
  logic       bus_dout_en;
  logic       link_stop;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_last;
  logic       tx_ready;
  logic       xrst_req;
  logic       xrst_done;
  logic       tx_abort;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_is_status;

  ulpi_link_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .phy_drives   (phy_drives),
    .phy_accept   (phy_accept),
    .bus_din      (bus_din),
    .bus_dout     (bus_dout),
    .bus_dout_en  (bus_dout_en),
    .link_stop    (link_stop),
    .tx_data      (tx_data),
    .tx_valid     (tx_valid),
    .tx_last      (tx_last),
    .tx_ready     (tx_ready),
    .xrst_req     (xrst_req),
    .xrst_done    (xrst_done),
    .tx_abort     (tx_abort),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_is_status (rx_is_status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  bit         phy_rx = 0;
  bit         sb_en = 1;
  logic [7:0] acc_pat = 8'hFF;
  int         acc_cnt = 0;
  int         last_acc_cyc = -10;
  int         stop_cnt = 0;
  int         aborts = 0;
  int         dones = 0;
  int         lowrun = 0;

  logic [8:0] exp_q[$];
  logic [8:0] rx_q[$];

  bit         p_dir = 0, p_acc = 0, p_oe = 0, p_stop = 0;
  logic [7:0] p_dout = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Scoreboard pushes.
  task automatic expect_pkt(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) exp_q.push_back({1'b0, seed + 8'(i*3)});
    exp_q.push_back(END_MARK);
  endtask

  task automatic expect_regw();
    exp_q.push_back(9'h084);   // R6 command byte
    exp_q.push_back(9'h020);   // R6 data byte
    exp_q.push_back(END_MARK);
  endtask

  // Upstream driver: presents bytes back to back until each is taken.
  task automatic send_pkt(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_data  = seed + 8'(i*3);
      tx_last  = (i == n-1);
      tx_valid = 1'b1;
      #2;
      while (!tx_ready) begin
        @(negedge clk);
        #2;
      end
    end
    @(negedge clk);
    tx_valid = 1'b0;
    tx_last  = 1'b0;
  endtask

  task automatic xrst_pulse();
    @(negedge clk);
    xrst_req = 1'b1;
    @(negedge clk);
    xrst_req = 1'b0;
  endtask

  // PHY receive burst: turnaround byte, n bytes with accept pattern, release.
  task automatic phy_burst(input int n, input logic [7:0] seed, input logic [7:0] pat);
    @(negedge clk);
    #2 phy_rx = 1;
    @(negedge clk);
    phy_drives = 1'b1;
    phy_accept = 1'b1;
    bus_din    = 8'hEE;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_din    = seed + 8'(i);
      phy_accept = pat[i%8];
      rx_q.push_back({!pat[i%8], seed + 8'(i)});
    end
    @(negedge clk);
    phy_drives = 1'b0;
    phy_accept = 1'b0;
    bus_din    = 8'h00;
    @(negedge clk);
    #2 phy_rx = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // PHY model and monitor.
  always @(negedge clk) begin
    if (!phy_rx) phy_accept = bus_dout_en && !link_stop && acc_pat[cyc%8];
    #1;
    cyc++;
    if (rst_n) begin
      if (bus_dout_en && !link_stop && !phy_drives && phy_accept) begin
        acc_cnt++;
        last_acc_cyc = cyc;
        if (sb_en) begin
          if (exp_q.size() == 0) chk(0, "R4", bus_dout, 'h1FF);
          else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk(e == {1'b0, bus_dout}, "R4", bus_dout, e);
          end
        end
      end
      if (link_stop) begin
        stop_cnt++;
        chk(bus_dout == 8'h00, "R5", bus_dout, 0);
        chk(last_acc_cyc == cyc-1, "R5", last_acc_cyc, cyc-1);
        if (sb_en) begin
          if (exp_q.size() == 0) chk(0, "R5", 0, END_MARK);
          else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk(e == END_MARK, "R5", e, END_MARK);
          end
        end
      end
      if (p_stop) chk(!link_stop && !bus_dout_en, "R5", {link_stop, bus_dout_en}, 0);
      if (p_oe && bus_dout_en && !p_acc && !p_dir)
        chk(bus_dout == p_dout, "R4", bus_dout, p_dout);
      if (p_dir) chk(!bus_dout_en, "R2", bus_dout_en, 0);
      if (bus_dout_en && !p_oe) chk(lowrun >= 2, "R3", lowrun, 2);
      if (tx_abort) begin
        aborts++;
        chk(!link_stop && !bus_dout_en, "R8", {link_stop, bus_dout_en}, 0);
      end
      if (xrst_done) dones++;
      if (rx_valid) begin
        if (rx_q.size() == 0) chk(0, "R10", {rx_is_status, rx_data}, 'h1FF);
        else begin
          logic [8:0] e;
          e = rx_q.pop_front();
          chk(e == {rx_is_status, rx_data}, "R10", {rx_is_status, rx_data}, e);
        end
      end
    end
    lowrun = phy_drives ? 0 : lowrun + 1;
    p_dir  = phy_drives;
    p_acc  = phy_accept;
    p_oe   = bus_dout_en;
    p_stop = link_stop;
    p_dout = bus_dout;
    if (cyc > WDOG_LIMIT) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  initial begin
    rst_n      = 1'b0;
    phy_drives = 1'b0;
    phy_accept = 1'b0;
    bus_din    = 8'h00;
    tx_data    = 8'h00;
    tx_valid   = 1'b0;
    tx_last    = 1'b0;
    xrst_req   = 1'b0;
    idle(5);
    #3;
    // R1: quiet outputs during reset
    chk(!bus_dout_en && !link_stop && !rx_valid && !tx_abort && !xrst_done, "R1",
        {bus_dout_en, link_stop, rx_valid, tx_abort, xrst_done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    chk(!bus_dout_en && !link_stop && !rx_valid && !tx_abort && !xrst_done, "R1",
        {bus_dout_en, link_stop, rx_valid, tx_abort, xrst_done}, 0);

    // R4 R5: packets under several accept patterns
    acc_pat = 8'hFF;
    expect_pkt(4, 8'h10);
    send_pkt(4, 8'h10);
    idle(10);
    acc_pat = 8'b10110010;
    expect_pkt(5, 8'h30);
    send_pkt(5, 8'h30);
    idle(10);
    acc_pat = 8'b00010001;
    expect_pkt(1, 8'h55);
    expect_pkt(3, 8'h60);
    send_pkt(1, 8'h55);
    send_pkt(3, 8'h60);
    idle(20);
    chk(exp_q.size() == 0, "R4", exp_q.size(), 0);

    // R6: transceiver reset write on an idle bus
    acc_pat = 8'b01011011;
    expect_regw();
    xrst_pulse();
    idle(15);
    chk(dones == 1, "R6", dones, 1);
    chk(exp_q.size() == 0, "R6", exp_q.size(), 0);

    // R10: receive burst with mixed data/status
    phy_burst(6, 8'hA0, 8'b01101001);
    idle(5);
    chk(rx_q.size() == 0, "R10", rx_q.size(), 0);

    // R7 R3: write and packet both wait while the PHY owns the bus
    acc_pat = 8'hFF;
    expect_regw();
    expect_pkt(3, 8'h90);
    fork
      phy_burst(4, 8'hC0, 8'hFF);
      begin
        idle(3);
        fork
          xrst_pulse();
          send_pkt(3, 8'h90);
        join
      end
    join
    idle(15);
    chk(dones == 2, "R7", dones, 2);
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);

    // R8: PHY takes the bus during a packet
    begin
      int base_acc;
      int base_stop;
      base_acc  = acc_cnt;
      base_stop = stop_cnt;
      sb_en = 0;
      fork
        send_pkt(6, 8'h40);
        begin
          wait (acc_cnt == base_acc + 2);
          phy_burst(3, 8'h70, 8'b00000101);
        end
      join
      idle(10);
      chk(aborts == 1, "R8", aborts, 1);
      chk(stop_cnt == base_stop, "R8", stop_cnt, base_stop);
      chk(acc_cnt - base_acc < 6, "R8", acc_cnt - base_acc, 5);
      sb_en = 1;
    end
    expect_pkt(2, 8'hE0);
    send_pkt(2, 8'hE0);
    idle(10);
    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);

    // R9: register write cut off before its command is accepted
    @(negedge clk);
    #2 phy_rx = 1;
    phy_accept = 1'b0;
    expect_regw();
    xrst_pulse();
    idle(4);
    phy_burst(2, 8'h11, 8'h00);
    idle(20);
    chk(aborts == 2, "R9", aborts, 2);
    chk(dones == 3, "R9", dones, 3);
    chk(exp_q.size() == 0, "R9", exp_q.size(), 0);
    chk(rx_q.size() == 0, "R10", rx_q.size(), 0);

    summary();
  end

endmodule